// File: doc/BRIEF.md
# Byte Mailbox Between Host Bus and Companion Processor

This block is a four-byte register file that lets a host CPU and a companion processor exchange bytes. Two of the bytes carry traffic from the host to the companion: a control byte and a data byte. The other two carry traffic back: again a control byte and a data byte. The host reaches the bytes through a small memory-mapped window. The companion uses its own two-bit register port. Neither side masters a bus; the block only answers accesses.

Host accesses decode only while the bank-select input is high and the byte address lies between 0x5FF8 and 0x5FFF. Odd addresses in that window select a byte. Each side may write only the bytes that travel away from it. The host may read all four bytes, and the companion may read only the two host-to-companion bytes. Reads are combinational from the stored bytes. A write becomes visible on the cycle after the clock edge that stores it.

Top module: `byte_mailbox`

## Requirements
- R1: After reset, all four stored bytes read as 0x00 from both sides. The reset input is asynchronous and active-low, and it is released synchronously two clock edges after it deasserts.
- R2: A host write to 0x5FFD stores the host-to-companion control byte, and a host write to 0x5FFF stores the host-to-companion data byte. Each is visible from the next cycle on, to host reads at the same address and to companion reads at index 2 (control) or index 3 (data).
- R3: A host write to 0x5FF9 or 0x5FFB changes nothing.
- R4: A host access decodes only when host_sel is 1 and the address is odd and inside 0x5FF8..0x5FFF. In that case host_hit is 1. Otherwise host_hit is 0, host_rdata is 0x00 and a write has no effect.
- R5: A companion write to index 0 stores the companion-to-host control byte, which the host reads at 0x5FF9. A companion write to index 1 stores the companion-to-host data byte, which the host reads at 0x5FFB.
- R6: A companion write to index 2 or 3 changes nothing.
- R7: A companion read of index 0 or 1 returns 0x00. A companion read of index 2 or 3 returns the stored host-to-companion byte.
- R8: If the companion writes a byte in the same cycle that the host reads it, the host sees the old value in that cycle and the new value from the next cycle on.
- R9: A host write and a companion write in the same cycle both take effect, each on its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Bank select that enables host decode |
| host_addr | input | 16 | Host byte address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, 0x00 when not decoded |
| host_hit | output | 1 | Host address decodes to a stored byte |
| cmp_addr | input | 2 | Companion register index |
| cmp_we | input | 1 | Companion write strobe |
| cmp_wdata | input | 8 | Companion write byte |
| cmp_rdata | output | 8 | Companion read byte |

## Verification
The host read path and the companion write path can hit the same companion-to-host byte in one cycle. The bench provokes this by holding a host read of 0x5FFB while the companion writes index 1 before the clock edge. It passes only if the host reads the old byte before that edge and the new byte after it. The bench also lets a host write and a companion write land on the same edge. It then reads both bytes back to show that neither write disturbed the other.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_LAT = 4;
  localparam int unsigned IDX_W   = $clog2(NUM_LAT);
  // index bit 1 set marks a host-to-companion byte
  typedef enum logic [IDX_W-1:0] {
    LAT_IN_CTRL  = 2'd0,
    LAT_IN_DATA  = 2'd1,
    LAT_OUT_CTRL = 2'd2,
    LAT_OUT_DATA = 2'd3
  } lat_idx_e;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
  import mbx_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]    WIN_BASE = 16'h5FF8
) (
  input  logic                  sel,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  output logic                  hit,
  output logic [IDX_W-1:0]      idx,
  output logic [NUM_LAT-1:0]    wr_oh
);
  localparam int unsigned WIN_LSB = IDX_W + 1;

  logic win_match;

  always_comb begin
    win_match = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
    hit       = sel && win_match && addr[0];
    idx       = addr[WIN_LSB-1:1];
  end

  for (genvar i = 0; i < NUM_LAT; i++) begin : g_wr
    always_comb wr_oh[i] = hit && we && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/mbx_latch_bank.sv
module mbx_latch_bank
  import mbx_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_q_n,
  input  logic [NUM_LAT-1:0]                host_wr_oh,
  input  logic [DATA_W-1:0]                 host_wdata,
  input  logic [NUM_LAT-1:0]                cmp_wr_oh,
  input  logic [DATA_W-1:0]                 cmp_wdata,
  output logic [NUM_LAT-1:0][DATA_W-1:0]    lat_q
);
  logic [NUM_LAT-1:0][DATA_W-1:0] lat_nxt;
  logic [NUM_LAT-1:0]             lat_en;

  for (genvar i = 0; i < NUM_LAT; i++) begin : g_lat
    if (i >= NUM_LAT/2) begin : g_outbound
      // host side owns this byte
      always_comb begin
        lat_en[i]  = host_wr_oh[i];
        lat_nxt[i] = lat_en[i] ? host_wdata : lat_q[i];
      end
    end else begin : g_inbound
      // companion side owns this byte
      always_comb begin
        lat_en[i]  = cmp_wr_oh[i];
        lat_nxt[i] = lat_en[i] ? cmp_wdata : lat_q[i];
      end
    end

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) lat_q[i] <= '0;
      else          lat_q[i] <= lat_nxt[i];
    end
  end
endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h5FF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_hit,
  input  logic [1:0]        cmp_addr,
  input  logic              cmp_we,
  input  logic [7:0]        cmp_wdata,
  output logic [7:0]        cmp_rdata
);
  logic                           rst_q_n;
  logic [IDX_W-1:0]               host_idx;
  logic [NUM_LAT-1:0]             host_wr_oh;
  logic [NUM_LAT-1:0]             cmp_wr_oh;
  logic [NUM_LAT-1:0][DATA_W-1:0] lat_q;

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  mbx_host_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .sel   (host_sel),
    .addr  (host_addr),
    .we    (host_we),
    .hit   (host_hit),
    .idx   (host_idx),
    .wr_oh (host_wr_oh)
  );

  for (genvar i = 0; i < NUM_LAT; i++) begin : g_cmp_wr
    always_comb cmp_wr_oh[i] = cmp_we && (cmp_addr == IDX_W'(i));
  end

  mbx_latch_bank u_bank (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .host_wr_oh (host_wr_oh),
    .host_wdata (host_wdata),
    .cmp_wr_oh  (cmp_wr_oh),
    .cmp_wdata  (cmp_wdata),
    .lat_q      (lat_q)
  );

  always_comb begin
    host_rdata = host_hit ? lat_q[host_idx] : '0;
    cmp_rdata  = cmp_addr[IDX_W-1] ? lat_q[cmp_addr] : '0;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h5FF8
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              host_sel,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_we,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              host_hit,
  input logic [1:0]        cmp_addr,
  input logic              cmp_we,
  input logic [7:0]        cmp_wdata,
  input logic [7:0]        cmp_rdata,
  input logic [3:0][7:0]   lat_q
);
  localparam logic [ADDR_W-1:0] A_IN_CTRL  = WIN_BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OUT_CTRL = WIN_BASE + ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_OUT_DATA = WIN_BASE + ADDR_W'(7);

  AST_HOST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (host_sel && host_we && host_addr == A_OUT_CTRL) |=> lat_q[2] == $past(host_wdata)); // R2
  AST_HOST_IN_IGNORE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (host_sel && host_we && host_addr == A_IN_CTRL && !(cmp_we && cmp_addr == 2'd0))
      |=> $stable(lat_q[0])); // R3
  AST_NOSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !host_sel |-> (!host_hit && host_rdata == 8'h00)); // R4
  AST_CMP_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmp_we && cmp_addr == 2'd1) |=> lat_q[1] == $past(cmp_wdata)); // R5
  AST_CMP_OUT_IGNORE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmp_we && cmp_addr == 2'd3 && !(host_sel && host_we && host_addr == A_OUT_DATA))
      |=> $stable(lat_q[3])); // R6
  AST_CMP_IN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cmp_addr[1] |-> cmp_rdata == 8'h00); // R7
endmodule

bind byte_mailbox mbx_checker #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .host_sel   (host_sel),
  .host_addr  (host_addr),
  .host_we    (host_we),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .host_hit   (host_hit),
  .cmp_addr   (cmp_addr),
  .cmp_we     (cmp_we),
  .cmp_wdata  (cmp_wdata),
  .cmp_rdata  (cmp_rdata),
  .lat_q      (lat_q)
);

// File: tb/sim_byte_mailbox.sv
`timescale 1ns/1ps
module sim_byte_mailbox;
  logic clk = 1'b0;
  logic rst_n;
  logic host_sel, host_we, host_hit, cmp_we;
  logic [15:0] host_addr;
  logic [7:0]  host_wdata, host_rdata, cmp_wdata, cmp_rdata;
  logic [1:0]  cmp_addr;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  byte_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
    .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_hit(host_hit), .cmp_addr(cmp_addr), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata)
  );

  // op: 0 host write, 1 host read check, 2 companion write, 3 companion read check
  // fields {op[1:0], addr[15:0], data[7:0], req[3:0]}
  localparam int NV = 21;
  localparam logic [29:0] TBL [NV] = '{
    {2'd1, 16'h5FF9, 8'h00, 4'd1},  // R1
    {2'd1, 16'h5FFB, 8'h00, 4'd1},  // R1
    {2'd1, 16'h5FFD, 8'h00, 4'd1},  // R1
    {2'd1, 16'h5FFF, 8'h00, 4'd1},  // R1
    {2'd0, 16'h5FFD, 8'hA5, 4'd2},  // R2
    {2'd0, 16'h5FFF, 8'h3C, 4'd2},  // R2
    {2'd3, 16'h0002, 8'hA5, 4'd2},  // R2
    {2'd3, 16'h0003, 8'h3C, 4'd2},  // R2
    {2'd1, 16'h5FFD, 8'hA5, 4'd2},  // R2
    {2'd0, 16'h5FF9, 8'h77, 4'd3},  // R3
    {2'd1, 16'h5FF9, 8'h00, 4'd3},  // R3
    {2'd2, 16'h0000, 8'h5A, 4'd5},  // R5
    {2'd2, 16'h0001, 8'hC3, 4'd5},  // R5
    {2'd1, 16'h5FF9, 8'h5A, 4'd5},  // R5
    {2'd1, 16'h5FFB, 8'hC3, 4'd5},  // R5
    {2'd2, 16'h0002, 8'hFF, 4'd6},  // R6
    {2'd3, 16'h0002, 8'hA5, 4'd6},  // R6
    {2'd3, 16'h0000, 8'h00, 4'd7},  // R7
    {2'd1, 16'h5FFC, 8'h00, 4'd4},  // R4 even address
    {2'd0, 16'h5FFE, 8'h11, 4'd4},  // R4 even address write
    {2'd1, 16'h5FFF, 8'h3C, 4'd4}   // R4 data byte untouched
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_sel = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    cmp_we = 1'b0; cmp_addr = '0; cmp_wdata = '0;
  endtask

  task automatic host_write(input logic [15:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    host_sel = sel; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic cmp_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cmp_we = 1'b1; cmp_addr = a; cmp_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic host_read(input logic [15:0] a, output logic [7:0] d, output logic h);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    #1;
    d = host_rdata; h = host_hit;
    idle();
  endtask

  task automatic cmp_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cmp_addr = a;
    #1;
    d = cmp_rdata;
    idle();
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    logic       h;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [15:0] a;
      logic [7:0]  d;
      logic [3:0]  r;
      {op, a, d, r} = TBL[i];
      case (op)
        2'd0: host_write(a, d, 1'b1);
        2'd2: cmp_write(a[1:0], d);
        2'd1: begin host_read(a, rd, h); chk(rd, d, $sformatf("R%0d vec%0d", r, i)); end
        default: begin cmp_read(a[1:0], rd); chk(rd, d, $sformatf("R%0d vec%0d", r, i)); end
      endcase
    end

    // R4: deselected write is dropped, deselected read is quiet
    host_write(16'h5FFD, 8'h99, 1'b0);
    host_read(16'h5FFD, rd, h);
    chk(rd, 8'hA5, "R4 nosel write");
    chk({7'd0, h}, 8'h01, "R4 hit on decode");
    @(negedge clk);
    host_sel = 1'b0; host_addr = 16'h5FFD; #1;
    chk(host_rdata, 8'h00, "R4 nosel rdata");
    chk({7'd0, host_hit}, 8'h00, "R4 nosel hit");
    idle();
    host_read(16'h6FFF, rd, h);
    chk(rd, 8'h00, "R4 outside window");

    // R8: companion write while host reads the same byte
    @(negedge clk);
    host_sel = 1'b1; host_addr = 16'h5FFB;
    cmp_we = 1'b1; cmp_addr = 2'd1; cmp_wdata = 8'h42;
    #1;
    chk(host_rdata, 8'hC3, "R8 old value");
    @(negedge clk);
    cmp_we = 1'b0; #1;
    chk(host_rdata, 8'h42, "R8 new value");
    idle();

    // R9: both sides write on the same edge
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = 16'h5FFF; host_wdata = 8'h81;
    cmp_we = 1'b1; cmp_addr = 2'd0; cmp_wdata = 8'h18;
    @(negedge clk);
    idle();
    cmp_read(2'd3, rd);
    chk(rd, 8'h81, "R9 host side");
    host_read(16'h5FF9, rd, h);
    chk(rd, 8'h18, "R9 companion side");

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    host_read(16'h5FF9, rd, h); chk(rd, 8'h00, "R1 in ctrl after reset");
    host_read(16'h5FFB, rd, h); chk(rd, 8'h00, "R1 in data after reset");
    cmp_read(2'd2, rd);         chk(rd, 8'h00, "R1 out ctrl after reset");
    cmp_read(2'd3, rd);         chk(rd, 8'h00, "R1 out data after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule